// File: doc/BRIEF.md
# Pipelined Binary-Trie Longest-Prefix Lookup

This block finds the longest matching prefix for a destination key by walking a binary trie that branches on one key bit at a time. Each trie level sits in its own pipeline stage with a private node memory. Every cycle a new lookup may enter. It leaves a fixed number of cycles later with a hit flag and the next hop of the deepest prefix node on its path. The root node stands for the zero-length prefix, so stage `i` holds prefixes of length `i`.

Node changes reach the memories by a separate route. Control logic first pushes one entry per stage into that stage's small update queue. It then raises a start pulse. A single token, the bubble, travels down the stages at the lookup rate. In each stage the bubble pops one queued entry and, if that entry is marked to write, stores it through the memory's write port. Lookups only ever use the read port, and a read returns the contents from before a write in the same cycle. A lookup that travels level with the bubble therefore sees the whole trie as it was before the update, and a lookup behind the bubble sees the whole trie after it. Lookups are never stalled.

Top module: `trie_lpm_pipe`

## Requirements
- R1: After reset `res_valid` and `res_hit` are low, `res_nh` is zero and no bubble is in flight.
- R2: A valid result has `res_hit` high and `res_nh` equal to the next hop of the deepest node on the key's path whose prefix-valid bit is set. The path starts at node 0 of stage 0. Stage `i` tests key bit `KEY_W-1-i`: 1 follows the right child and 0 follows the left child.
- R3: If no prefix node lies on the path, the result has `res_hit` low and `res_nh` zero.
- R4: When the chosen child is marked absent, the walk stops. The best match found so far is reported unchanged.
- R5: A lookup sampled at rising edge k gives its result on the outputs after edge k+KEY_W. A new lookup may be sampled at every edge.
- R6: A node word is, from MSB to LSB: left child index (`AW` bits), right child index (`AW`), left-valid, right-valid, prefix-valid, next hop (`NH_W`). A child index addresses a node in the next stage.
- R7: A push writes the entry {`upd_wen`, `upd_addr`, `upd_node`} into the queue of stage `upd_stage`. A push to a queue that already holds `FIFO_D` entries is dropped.
- R8: `bub_start` is ignored while any stage queue is empty or a bubble is already in flight.
- R9: An accepted start sampled at edge E makes stage i pop one queue entry at edge E+1+i.
- R10: A popped entry with `upd_wen` low leaves the memory unchanged.
- R11: Let E be the edge that samples an accepted start. A lookup sampled at or before edge E+1 sees the old contents in every stage. A lookup sampled at edge E+2 or later sees the new contents in every stage.
- R12: Prefixes of every length from 0 to `KEY_W-1` are matched, including those held in the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_key | input | KEY_W | Destination key |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A prefix matched |
| res_nh | output | NH_W | Next hop of the longest match, zero on a miss |
| upd_push | input | 1 | Push one update entry |
| upd_stage | input | $clog2(KEY_W) | Stage whose queue receives the entry |
| upd_wen | input | 1 | Entry performs a write when popped |
| upd_addr | input | AW | Node address within the stage |
| upd_node | input | 2*AW+NH_W+3 | Node word to store |
| bub_start | input | 1 | Request to inject a bubble |

## Verification
The hardest case is a lookup that reads a stage in the same cycle the bubble rewrites it. The case is sharpest when the update changes nodes in several stages at once, such as a new child pointer high in the trie together with newly created nodes below it. The bench reaches this case by streaming lookups every cycle on keys whose result depends on the update, and raising the start partway through the stream. A reference model switches from the old prefix table to the new one exactly between the lookups sampled at E+1 and E+2. Each streamed lookup must then return a wholly old or a wholly new answer. Queue overflow and start gating are reached by preloading several entries per stage and pulsing the start while a queue is empty or a bubble is still moving. The only visible effect is the next hop that later lookups return.

// File: rtl/trie_lpm_pipe.sv
module trie_lpm_pipe #(
  parameter int KEY_W  = 8,
  parameter int AW     = 4,
  parameter int NH_W   = 8,
  parameter int FIFO_D = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [KEY_W-1:0]           lk_key,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [NH_W-1:0]            res_nh,
  input  logic                       upd_push,
  input  logic [$clog2(KEY_W)-1:0]   upd_stage,
  input  logic                       upd_wen,
  input  logic [AW-1:0]              upd_addr,
  input  logic [2*AW+NH_W+2:0]       upd_node,
  input  logic                       bub_start
);
  localparam int NODE_W = 2*AW + NH_W + 3;
  localparam int SW     = $clog2(KEY_W);
  localparam int FPW    = $clog2(FIFO_D);
  localparam int ENT_W  = 1 + AW + NODE_W;
  localparam int PV     = NH_W;
  localparam int RV     = NH_W + 1;
  localparam int LV     = NH_W + 2;
  localparam int RC     = NH_W + 3;
  localparam int LC     = NH_W + 3 + AW;

  logic             iv     [KEY_W+1];
  logic             ialive [KEY_W+1];
  logic             ihit   [KEY_W+1];
  logic [KEY_W-1:0] ikey   [KEY_W+1];
  logic [AW-1:0]    iaddr  [KEY_W+1];
  logic [NH_W-1:0]  inh    [KEY_W+1];

  logic [KEY_W-1:0] bub_q, fifo_ne;
  wire start_ok = bub_start && (&fifo_ne) && !(|bub_q);

  assign iv[0]     = lk_valid;
  assign ikey[0]   = lk_key;
  assign iaddr[0]  = '0;
  assign ialive[0] = 1'b1;
  assign ihit[0]   = 1'b0;
  assign inh[0]    = '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bub_q <= '0;
    else        bub_q <= {bub_q[KEY_W-2:0], start_ok};

  for (genvar s = 0; s < KEY_W; s++) begin : g_stage
    logic [NODE_W-1:0] mem [2**AW];
    logic [ENT_W-1:0]  fq  [FIFO_D];
    logic [FPW-1:0]    wp, rp;
    logic [FPW:0]      cnt;
    logic [NODE_W-1:0] rd;
    logic              mv, malive, mhit;
    logic [KEY_W-1:0]  mkey;
    logic [NH_W-1:0]   mnh;

    wire             push  = upd_push && (upd_stage == SW'(s)) && (cnt != (FPW+1)'(FIFO_D));
    wire             pop   = bub_q[s];
    wire [ENT_W-1:0] head  = fq[rp];
    wire             wr    = pop && head[ENT_W-1];
    wire             right = mkey[KEY_W-1-s];
    wire             take  = malive && rd[PV];

    assign fifo_ne[s] = (cnt != '0);

    always_ff @(posedge clk)
      if (push) fq[wp] <= {upd_wen, upd_addr, upd_node};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push) wp <= wp + FPW'(1);
        if (pop)  rp <= rp + FPW'(1);
        if (push && !pop)      cnt <= cnt + (FPW+1)'(1);
        else if (!push && pop) cnt <= cnt - (FPW+1)'(1);
      end

    always_ff @(posedge clk) begin
      if (wr) mem[head[NODE_W+AW-1:NODE_W]] <= head[NODE_W-1:0];
      rd     <= mem[iaddr[s]];
      mkey   <= ikey[s];
      malive <= ialive[s];
      mhit   <= ihit[s];
      mnh    <= inh[s];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mv <= 1'b0;
      else        mv <= iv[s];

    assign iv[s+1]     = mv;
    assign ikey[s+1]   = mkey;
    assign ihit[s+1]   = take | mhit;
    assign inh[s+1]    = take ? rd[NH_W-1:0] : mnh;
    assign ialive[s+1] = malive && (right ? rd[RV] : rd[LV]);
    assign iaddr[s+1]  = right ? rd[RC +: AW] : rd[LC +: AW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_valid <= 1'b0; res_hit <= 1'b0; res_nh <= '0;
    end else begin
      res_valid <= iv[KEY_W];
      res_hit   <= iv[KEY_W] && ihit[KEY_W];
      res_nh    <= iv[KEY_W] ? inh[KEY_W] : '0;
    end
endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk #(
  parameter int KEY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             bub_start,
  input logic [KEY_W-1:0] bub_q,
  input logic [KEY_W-1:0] fifo_ne
);
  logic [KEY_W:0] vq;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vq <= '0;
    else        vq <= {vq[KEY_W-1:0], lk_valid};

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == vq[KEY_W]);

  assert_single_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bub_q));

  assert_start_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bub_start && !(&fifo_ne)) |=> !bub_q[0]);

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bub_start && (|bub_q)) |=> !bub_q[0]);

  assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bub_start && (&fifo_ne) && (bub_q == '0)) |=> bub_q[0]);

  assert_bubble_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|bub_q[KEY_W-2:0]) |=> (bub_q[KEY_W-1:1] == $past(bub_q[KEY_W-2:0])));
endmodule

bind trie_lpm_pipe trie_lpm_chk #(.KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
  .bub_start(bub_start), .bub_q(bub_q), .fifo_ne(fifo_ne)
);

// File: tb/tb_trie_lpm_pipe.sv
module tb_trie_lpm_pipe;
  localparam int KW  = 8;
  localparam int AW  = 4;
  localparam int NHW = 8;
  localparam int FD  = 4;
  localparam int NW  = 2*AW + NHW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lk_valid = 0, res_valid, res_hit;
  logic [KW-1:0] lk_key = '0;
  logic [NHW-1:0] res_nh;
  logic          upd_push = 0, upd_wen = 0, bub_start = 0;
  logic [2:0]    upd_stage = '0;
  logic [AW-1:0] upd_addr = '0;
  logic [NW-1:0] upd_node = '0;

  trie_lpm_pipe #(.KEY_W(KW), .AW(AW), .NH_W(NHW), .FIFO_D(FD)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh),
    .upd_push(upd_push), .upd_stage(upd_stage), .upd_wen(upd_wen),
    .upd_addr(upd_addr), .upd_node(upd_node), .bub_start(bub_start));

  int checks = 0, fails = 0;
  string req = "R1";

  int cur_len[32], cur_bits[32], cur_nh[32]; bit cur_on[32];
  int nxt_len[32], nxt_bits[32], nxt_nh[32]; bit nxt_on[32];
  logic [NW-1:0] sh [KW][16];
  int  alloc_n[KW];
  bit  pw_v[KW];
  int  pw_a[KW];

  bit  want_apply = 0;
  int  apply_at = -1, edge_n = 0, mj, mn;
  bit  mh;
  bit  ex_v[64], ex_hit[64];
  int  ex_nh[64];

  function automatic void model(input int key, output bit hit, output int nh);
    int best = -1;
    hit = 0; nh = 0;
    for (int p = 0; p < 32; p++)
      if (cur_on[p] && cur_len[p] > best &&
          ((key >> (KW - cur_len[p])) == (cur_bits[p] >> (KW - cur_len[p])))) begin
        best = cur_len[p]; hit = 1; nh = cur_nh[p];
      end
  endfunction

  always @(posedge clk) begin
    edge_n++;
    ex_v[edge_n % 64] = lk_valid;
    if (lk_valid) begin
      model(int'(lk_key), mh, mn);
      ex_hit[edge_n % 64] = mh; ex_nh[edge_n % 64] = mn;
    end
    if (edge_n == apply_at)
      for (int p = 0; p < 32; p++) begin
        cur_len[p] = nxt_len[p]; cur_bits[p] = nxt_bits[p];
        cur_nh[p] = nxt_nh[p]; cur_on[p] = nxt_on[p];
      end
    if (bub_start && want_apply) begin apply_at = edge_n + 1; want_apply = 0; end
  end

  always @(negedge clk)
    if (rst_n && edge_n > KW) begin
      mj = (edge_n - KW) % 64;
      if (ex_v[mj] || res_valid) begin
        checks++;
        if (res_valid !== ex_v[mj] ||
            (ex_v[mj] && (res_hit !== ex_hit[mj] || int'(res_nh) != ex_nh[mj]))) begin
          fails++;
          $display("FAIL %s: valid/hit/nh = %0b/%0b/%0h expected %0b/%0b/%0h", req,
                   res_valid, res_hit, res_nh, ex_v[mj], ex_hit[mj], ex_nh[mj]);
        end
      end
    end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: run still busy, expected completion");
    report();
  end

  task automatic set_route(int len, int bits, int nh, bit on);
    int slot = -1;
    for (int p = 0; p < 32; p++)
      if (slot < 0 && nxt_on[p] && nxt_len[p] == len && nxt_bits[p] == bits) slot = p;
    if (slot < 0)
      for (int p = 0; p < 32; p++) if (slot < 0 && !nxt_on[p]) slot = p;
    nxt_len[slot] = len; nxt_bits[slot] = bits; nxt_nh[slot] = nh; nxt_on[slot] = on;
  endtask

  task automatic clear_pw();
    for (int s = 0; s < KW; s++) pw_v[s] = 0;
  endtask

  task automatic mark(int s, int a);
    pw_v[s] = 1; pw_a[s] = a;
  endtask

  task automatic push(int st, bit w, int a, logic [NW-1:0] nd);
    @(negedge clk);
    upd_push = 1; upd_stage = 3'(st); upd_wen = w; upd_addr = AW'(a); upd_node = nd;
  endtask

  task automatic push_end();
    @(negedge clk); upd_push = 0;
  endtask

  // R6/R10: marked stages write shadow node; others push a non-writing all-ones entry at live node 0
  task automatic load_pw(int skip);
    for (int s = 0; s < KW; s++)
      if (s != skip) begin
        if (pw_v[s]) push(s, 1, pw_a[s], sh[s][pw_a[s]]);
        else         push(s, 0, 0, '1);
      end
    push_end();
  endtask

  task automatic kick(bit apply);
    want_apply = apply;
    @(negedge clk) bub_start = 1;
    @(negedge clk) bub_start = 0;
    repeat (KW + 3) @(negedge clk);
  endtask

  task automatic add_prefix(int len, int bits, int nh);
    int n = 0, nn, c;
    logic [NW-1:0] nd;
    clear_pw();
    for (int d = 0; d < len; d++) begin
      nd = sh[d][n];
      if (bits[KW-1-d] ? nd[NHW+1] : nd[NHW+2])
        nn = bits[KW-1-d] ? int'(nd[NHW+3 +: AW]) : int'(nd[NHW+3+AW +: AW]);
      else begin
        c = alloc_n[d+1]; alloc_n[d+1]++;
        sh[d+1][c] = '0;
        if (bits[KW-1-d]) begin sh[d][n][NHW+1] = 1; sh[d][n][NHW+3 +: AW] = AW'(c); end
        else              begin sh[d][n][NHW+2] = 1; sh[d][n][NHW+3+AW +: AW] = AW'(c); end
        mark(d, n); mark(d+1, c); nn = c;
      end
      n = nn;
    end
    sh[len][n][NHW] = 1; sh[len][n][NHW-1:0] = NHW'(nh); mark(len, n);
    set_route(len, bits, nh, 1);
  endtask

  task automatic set_root(bit pv, int nh);
    clear_pw();
    sh[0][0][NHW] = pv; sh[0][0][NHW-1:0] = NHW'(nh); mark(0, 0);
    set_route(0, 0, nh, pv);
  endtask

  task automatic sweep(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); lk_valid = 1; lk_key = KW'(k);
    end
    @(negedge clk) lk_valid = 0;
    repeat (KW + 3) @(negedge clk);
  endtask

  // R11: lookups every cycle while one bubble passes
  task automatic stream(int ka, int kb);
    fork
      begin
        for (int k = 0; k < 40; k++) begin
          @(negedge clk); lk_valid = 1; lk_key = KW'((k % 2) ? ka : kb);
        end
        @(negedge clk) lk_valid = 0;
      end
      begin
        repeat (12) @(negedge clk);
        want_apply = 1; bub_start = 1;
        @(negedge clk) bub_start = 0;
      end
    join
    repeat (KW + 3) @(negedge clk);
  endtask

  initial begin
    logic [NW-1:0] rt;
    for (int s = 0; s < KW; s++) begin
      alloc_n[s] = (s == 0) ? 1 : 0;
      for (int a = 0; a < 16; a++) sh[s][a] = '0;
    end
    for (int p = 0; p < 32; p++) begin nxt_on[p] = 0; cur_on[p] = 0; end

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (res_valid !== 0 || res_hit !== 0 || res_nh !== '0) begin
      fails++;
      $display("FAIL R1: valid/hit/nh = %0b/%0b/%0h expected 0/0/0", res_valid, res_hit, res_nh);
    end

    req = "R10"; clear_pw(); mark(0, 0); load_pw(-1); kick(1);

    req = "R8"; set_root(1, 'h11); load_pw(7); kick(0); sweep(16);
    push(7, 0, 0, '1); push_end();
    req = "R9"; kick(1); sweep(256);

    req = "R2";  add_prefix(1, 'h80, 'h21); load_pw(-1); kick(1); sweep(256);
    req = "R4";  add_prefix(3, 'hA0, 'h22); load_pw(-1); kick(1); sweep(256);
    req = "R12"; add_prefix(7, 'hAC, 'h23); load_pw(-1); kick(1); sweep(256);
    req = "R5";  add_prefix(2, 'h40, 'h24); load_pw(-1); kick(1); sweep(256);
    req = "R6";  add_prefix(5, 'h68, 'h25); load_pw(-1); kick(1); sweep(256);
    req = "R3";  set_root(0, 0);            load_pw(-1); kick(1); sweep(256);

    req = "R11"; add_prefix(6, 'h14, 'h26); load_pw(-1); stream('h17, 'hAD);
    add_prefix(7, 'hAC, 'h27); load_pw(-1); stream('hAD, 'h17);
    sweep(256);

    req = "R7";
    for (int j = 0; j < 5; j++) begin
      rt = sh[0][0]; rt[NHW] = 1; rt[NHW-1:0] = NHW'('h31 + j);
      push(0, 1, 0, rt);
    end
    for (int s = 1; s < KW; s++) for (int j = 0; j < FD; j++) push(s, 0, 0, '1);
    push_end();
    for (int j = 0; j < FD; j++) begin
      set_route(0, 0, 'h31 + j, 1); kick(1); sweep(64);
    end
    sh[0][0][NHW] = 1; sh[0][0][NHW-1:0] = 'h34;
    req = "R8"; kick(0); sweep(256);

    for (int j = 0; j < 2; j++) begin
      rt = sh[0][0]; rt[NHW-1:0] = NHW'('h41 + j);
      push(0, 1, 0, rt);
    end
    for (int s = 1; s < KW; s++) for (int j = 0; j < 2; j++) push(s, 0, 0, '1);
    push_end();
    set_route(0, 0, 'h41, 1); want_apply = 1;
    @(negedge clk) bub_start = 1;
    @(negedge clk);
    @(negedge clk) bub_start = 0;
    repeat (KW + 3) @(negedge clk);
    sweep(64);
    req = "R9"; set_route(0, 0, 'h42, 1); kick(1); sweep(64);
    sh[0][0][NHW-1:0] = 'h42;

    report();
  end
endmodule